// File: doc/BRIEF.md
# Low-Power Mode and Wakeup Sequencer

This block moves a small microcontroller between normal execution and two power-saving states. A stop state shuts the oscillator down completely. A doze state keeps the oscillator and one timer running while the core clocks are gated off. Software requests a state through one-cycle write strobes. An external wakeup line, an internal timer or reset brings the core back.

A single down-counting span timer does two jobs, and it is advanced by an instruction-cycle tick taken from a fixed divider. When the core leaves the stop state on a crystal or resonator clock, the timer holds the core clocks off until the oscillator has had time to settle. On an R/C clock that settling wait is optional and is selected by a software delay bit. In the doze state the same timer sets a wake period of a fixed power of two in ticks, after which the core resumes on its own.

The block also drives the controls that belong to these states:
- a watchdog inhibit;
- the clock pad state, pulled high or floated;
- a pulse that marks a resume at the point where execution stopped;
- a flag that marks a restart from address zero after reset.

Top module: `lpm_ctrl`

## Requirements
- R1: Synchronous reset puts the block in run: `core_clk_en`=1, `osc_en`=1, both flags 0, `wdog_inhibit`=0. `restart_zero` is 1 in the cycle after the last reset edge and 0 after that. Reset clears the settle-delay bit.
- R2: `tc_tick` pulses for one cycle in every `DIV` cycles while the oscillator runs.
- R3: A `halt_wr` strobe in run with `halt_en`=1 enters the stop state at the next edge. In that state `halt_flag`=1, `core_clk_en`=0, `osc_en`=0 and `wdog_inhibit`=1.
- R4: When `halt_en`=0, a `halt_wr` strobe has no effect. `halt_flag` stays 0 and `core_clk_en` stays 1.
- R5: With `osc_rc`=0 (crystal), a rising wakeup in the stop state turns on `osc_en` first. `core_clk_en` returns exactly `SETTLE_TC`×`DIV` cycles later. The state is entered 3 cycles after the wakeup input rises, because of the 2-flop synchronizer and the edge stage.
- R6: With `osc_rc`=1 (R/C), the same settle delay applies only when the delay bit is 1. When the bit is 0, the core resumes in the same cycle that the settle would have begun.
- R7: In the stop state, `cki_force_high`=1 when `osc_rc`=1 and `cki_tristate`=1 when `osc_rc`=0. Outside the stop state both are 0.
- R8: An `idle_wr` strobe in run enters the doze state: `idle_flag`=1, `core_clk_en`=0, `osc_en`=1. The block returns to run on its own after 2^`IDLE_EXP`×`DIV` cycles.
- R9: A rising wakeup during doze returns the block to run 3 cycles after the input rises.
- R10: When `halt_wr` and `idle_wr` arrive together, the stop state wins if `halt_en`=1. If `halt_en`=0, the doze state is entered.
- R11: `resume_pulse` is high for exactly the first run cycle after any return from stop or doze, and both flags are 0 then. Reset during the stop state forces run with `restart_zero` and without `resume_pulse`.
- R12: Wakeup acts only on a rising edge, and only in stop or doze. A wakeup line that is held high does not wake a later stop state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_wr | input | 1 | Strobe: software writes 1 to the stop flag |
| idle_wr | input | 1 | Strobe: software writes 1 to the doze flag |
| halt_en | input | 1 | Option: stop state allowed |
| clkdly_wr | input | 1 | Strobe: load the settle-delay bit |
| clkdly_d | input | 1 | Value for the settle-delay bit |
| osc_rc | input | 1 | 1 = R/C clock source, 0 = crystal/resonator/external |
| wake_req | input | 1 | Asynchronous wakeup request from the wakeup pins |
| core_clk_en | output | 1 | Core clocks enabled |
| osc_en | output | 1 | Oscillator enabled |
| wdog_inhibit | output | 1 | Watchdog held off |
| cki_force_high | output | 1 | Clock pad driven high internally |
| cki_tristate | output | 1 | Clock pad floated |
| halt_flag | output | 1 | Stop flag read-back (includes settling) |
| idle_flag | output | 1 | Doze flag read-back |
| resume_pulse | output | 1 | One cycle: resume at the stop point |
| restart_zero | output | 1 | Restart at address zero after reset |
| tc_tick | output | 1 | Instruction-cycle tick |

## Verification
The bench builds the block with `DIV`=3, `SETTLE_TC`=8 and `IDLE_EXP`=4. With these values the 24-cycle settle window and the 48-cycle doze period can be measured to the exact cycle in a short run. The stop-and-wake sequence is swept over all four combinations of clock source and delay bit, with the expected return cycle computed from these parameters. The priority, write-ignore, held-wakeup and reset-in-stop cases each run from a fresh reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LPM_RUN    = 2'd0,
        LPM_HALT   = 2'd1,
        LPM_SETTLE = 2'd2,
        LPM_IDLE   = 2'd3
    } lpm_mode_e;

    typedef struct packed {
        logic core_en;
        logic osc_en;
        logic wd_inh;
        logic pad_hi;
        logic pad_z;
        logic halt_f;
        logic idle_f;
    } lpm_ctl_t;

    function automatic lpm_ctl_t lpm_decode(input lpm_mode_e m, input logic rc);
        lpm_ctl_t c;
        c.core_en = (m == LPM_RUN);
        c.osc_en  = (m != LPM_HALT);
        c.wd_inh  = (m == LPM_HALT) || (m == LPM_SETTLE);
        c.pad_hi  = (m == LPM_HALT) && rc;
        c.pad_z   = (m == LPM_HALT) && !rc;
        c.halt_f  = (m == LPM_HALT) || (m == LPM_SETTLE);
        c.idle_f  = (m == LPM_IDLE);
        return c;
    endfunction

endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= 3'b000;
        else     sh <= {sh[1:0], async_in};
    end

    assign rise = sh[1] & ~sh[2];

    a_r12_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/lpm_tick_div.sv
module lpm_tick_div #(
    parameter int DIV = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || !run)            cnt <= '0;
        else if (cnt == DW'(DIV - 1))      cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == DW'(DIV - 1));

    a_r2_div_range: assert property (@(posedge clk) disable iff (rst)
        cnt < DW'(DIV));
endmodule

// File: rtl/lpm_span_timer.sv
module lpm_span_timer #(
    parameter int TW   = 13,
    parameter int MAXV = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [TW-1:0] ld_val,
    input  logic          tick,
    output logic          expire
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (ld)                 cnt <= ld_val;
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expire = tick && (cnt == TW'(1));

    a_r8_timer_cap: assert property (@(posedge clk) disable iff (rst)
        cnt <= TW'(MAXV));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int DIV       = 9,
    parameter int SETTLE_TC = 256,
    parameter int IDLE_EXP  = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic halt_wr,
    input  logic idle_wr,
    input  logic halt_en,
    input  logic clkdly_wr,
    input  logic clkdly_d,
    input  logic osc_rc,
    input  logic wake_req,
    output logic core_clk_en,
    output logic osc_en,
    output logic wdog_inhibit,
    output logic cki_force_high,
    output logic cki_tristate,
    output logic halt_flag,
    output logic idle_flag,
    output logic resume_pulse,
    output logic restart_zero,
    output logic tc_tick
);
    localparam int IDLE_TC = 1 << IDLE_EXP;
    localparam int MAXV    = (SETTLE_TC > IDLE_TC) ? SETTLE_TC : IDLE_TC;
    localparam int TW      = $clog2(MAXV + 1);

    lpm_mode_e     mode, mode_n;
    lpm_ctl_t      ctl;
    logic          clkdly_q;
    logic          wake_rise;
    logic          tmr_ld;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;

    lpm_wake_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (wake_req),
        .rise     (wake_rise)
    );

    lpm_tick_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (ctl.osc_en),
        .clr  (tmr_ld),
        .tick (tc_tick)
    );

    lpm_span_timer #(.TW(TW), .MAXV(MAXV)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .ld     (tmr_ld),
        .ld_val (tmr_val),
        .tick   (tc_tick),
        .expire (tmr_exp)
    );

    always_comb begin
        mode_n  = mode;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        unique case (mode)
            LPM_RUN: begin
                if (halt_wr && halt_en) begin
                    mode_n = LPM_HALT;
                end else if (idle_wr) begin
                    mode_n  = LPM_IDLE;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(IDLE_TC);
                end
            end
            LPM_HALT: begin
                if (wake_rise) begin
                    if (!osc_rc || clkdly_q) begin
                        mode_n  = LPM_SETTLE;
                        tmr_ld  = 1'b1;
                        tmr_val = TW'(SETTLE_TC);
                    end else begin
                        mode_n = LPM_RUN;
                    end
                end
            end
            LPM_SETTLE: if (tmr_exp) mode_n = LPM_RUN;
            LPM_IDLE:   if (wake_rise || tmr_exp) mode_n = LPM_RUN;
            default:    mode_n = LPM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= LPM_RUN;
            clkdly_q <= 1'b0;
        end else begin
            mode <= mode_n;
            if (clkdly_wr) clkdly_q <= clkdly_d;
        end
        restart_zero <= rst;
        resume_pulse <= !rst && (mode != LPM_RUN) && (mode_n == LPM_RUN);
    end

    assign ctl            = lpm_decode(mode, osc_rc);
    assign core_clk_en    = ctl.core_en;
    assign osc_en         = ctl.osc_en;
    assign wdog_inhibit   = ctl.wd_inh;
    assign cki_force_high = ctl.pad_hi;
    assign cki_tristate   = ctl.pad_z;
    assign halt_flag      = ctl.halt_f;
    assign idle_flag      = ctl.idle_f;

    a_r4_halt_blocked: assert property (@(posedge clk) disable iff (rst)
        (!halt_en && mode == LPM_RUN) |=> (mode != LPM_HALT));

    a_r5_settle_exit: assert property (@(posedge clk) disable iff (rst)
        (mode == LPM_SETTLE) |=> (mode == LPM_SETTLE || mode == LPM_RUN));

    a_r7_pad_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cki_force_high, cki_tristate}));

    a_r9_idle_wake: assert property (@(posedge clk) disable iff (rst)
        (mode == LPM_IDLE && wake_rise) |=> (mode == LPM_RUN));

    a_r11_resume: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) != LPM_RUN && mode == LPM_RUN) |-> resume_pulse);
endmodule

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 3;
    localparam int STC = 8;
    localparam int IEX = 4;
    localparam int SETTLE_CYC = STC * DIV;
    localparam int IDLE_CYC   = (1 << IEX) * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_wr = 0, idle_wr = 0, halt_en = 1, clkdly_wr = 0, clkdly_d = 0;
    logic osc_rc = 0, wake_req = 0;
    logic core_clk_en, osc_en, wdog_inhibit, cki_force_high, cki_tristate;
    logic halt_flag, idle_flag, resume_pulse, restart_zero, tc_tick;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lpm_ctrl #(.DIV(DIV), .SETTLE_TC(STC), .IDLE_EXP(IEX)) i_lpm_ctrl (
        .clk(clk), .rst(rst), .halt_wr(halt_wr), .idle_wr(idle_wr),
        .halt_en(halt_en), .clkdly_wr(clkdly_wr), .clkdly_d(clkdly_d),
        .osc_rc(osc_rc), .wake_req(wake_req), .core_clk_en(core_clk_en),
        .osc_en(osc_en), .wdog_inhibit(wdog_inhibit),
        .cki_force_high(cki_force_high), .cki_tristate(cki_tristate),
        .halt_flag(halt_flag), .idle_flag(idle_flag),
        .resume_pulse(resume_pulse), .restart_zero(restart_zero),
        .tc_tick(tc_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic strobe_halt();
        @(negedge clk); halt_wr = 1'b1;
        @(negedge clk); halt_wr = 1'b0;
    endtask

    // returns negedges counted from raising wake_req until core_clk_en
    task automatic wake_and_count(output int k);
        @(negedge clk); wake_req = 1'b1;
        k = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); k++;
            if (core_clk_en) break;
        end
    endtask

    initial begin
        int k, ticks, first_t, second_t;
        do_reset();
        // R1 reset state
        check("R1 core_clk_en", core_clk_en, 1);
        check("R1 osc_en", osc_en, 1);
        check("R1 flags", {30'd0, halt_flag, idle_flag}, 0);
        check("R1 wdog_inhibit", wdog_inhibit, 0);
        check("R1 restart_zero first", restart_zero, 1);
        @(negedge clk);
        check("R1 restart_zero later", restart_zero, 0);

        // R2 tick spacing
        ticks = 0; first_t = -1; second_t = -1;
        for (int i = 0; i < 10 * DIV; i++) begin
            @(negedge clk);
            if (tc_tick) begin
                ticks++;
                if (first_t < 0) first_t = i;
                else if (second_t < 0) second_t = i;
            end
        end
        check("R2 tick count", ticks, 10);
        check("R2 tick spacing", second_t - first_t, DIV);

        // R3 R5 R6 R7 R11 sweep over clock source and delay bit
        for (int rc = 0; rc < 2; rc++) begin
            for (int dl = 0; dl < 2; dl++) begin
                int exp_k;
                do_reset();
                osc_rc = rc[0]; halt_en = 1'b1;
                @(negedge clk); clkdly_wr = 1'b1; clkdly_d = dl[0];
                @(negedge clk); clkdly_wr = 1'b0;
                strobe_halt();
                check("R3 halt_flag", halt_flag, 1);
                check("R3 core off", core_clk_en, 0);
                check("R3 osc off", osc_en, 0);
                check("R3 wdog_inhibit", wdog_inhibit, 1);
                check("R7 pad high", cki_force_high, rc);
                check("R7 pad tristate", cki_tristate, 1 - rc);
                repeat (4) @(negedge clk);
                exp_k = (rc == 1 && dl == 0) ? 3 : 3 + SETTLE_CYC;
                wake_and_count(k);
                check(rc == 0 ? "R5 settle length" : "R6 rc delay length", k, exp_k);
                check("R11 resume_pulse", resume_pulse, 1);
                check("R11 halt_flag cleared", halt_flag, 0);
                check("R7 pads off in run", {30'd0, cki_force_high, cki_tristate}, 0);
                wake_req = 1'b0;
                @(negedge clk);
                check("R11 resume one cycle", resume_pulse, 0);
            end
        end

        // R5 oscillator on before core during settle
        do_reset(); osc_rc = 1'b0;
        strobe_halt();
        @(negedge clk); wake_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 osc on during settle", osc_en, 1);
        check("R5 core still off", core_clk_en, 0);
        check("R5 halt_flag during settle", halt_flag, 1);
        wake_req = 1'b0;

        // R1 delay bit cleared by reset
        do_reset(); osc_rc = 1'b1;
        @(negedge clk); clkdly_wr = 1'b1; clkdly_d = 1'b1;
        @(negedge clk); clkdly_wr = 1'b0;
        do_reset();
        strobe_halt();
        repeat (2) @(negedge clk);
        wake_and_count(k);
        check("R1 delay bit cleared", k, 3);
        wake_req = 1'b0;

        // R4 halt disabled
        do_reset(); halt_en = 1'b0;
        strobe_halt();
        check("R4 halt_flag stays 0", halt_flag, 0);
        repeat (3) @(negedge clk);
        check("R4 core stays on", core_clk_en, 1);
        halt_en = 1'b1;

        // R10 priority
        do_reset();
        @(negedge clk); halt_wr = 1'b1; idle_wr = 1'b1;
        @(negedge clk); halt_wr = 1'b0; idle_wr = 1'b0;
        check("R10 halt wins", {30'd0, halt_flag, idle_flag}, 2);
        do_reset(); halt_en = 1'b0;
        @(negedge clk); halt_wr = 1'b1; idle_wr = 1'b1;
        @(negedge clk); halt_wr = 1'b0; idle_wr = 1'b0;
        check("R10 idle when halt disabled", {30'd0, halt_flag, idle_flag}, 1);
        halt_en = 1'b1;

        // R8 idle timeout
        do_reset(); osc_rc = 1'b0;
        @(negedge clk); idle_wr = 1'b1;
        k = 0;
        @(negedge clk); idle_wr = 1'b0; k = 1;
        check("R8 idle_flag", idle_flag, 1);
        check("R8 core off", core_clk_en, 0);
        check("R8 osc on", osc_en, 1);
        while (!core_clk_en && k < 500) begin
            @(negedge clk); k++;
        end
        check("R8 idle period", k, 1 + IDLE_CYC);
        check("R8 resume_pulse", resume_pulse, 1);
        check("R8 idle_flag cleared", idle_flag, 0);

        // R9 wakeup during idle
        do_reset();
        @(negedge clk); idle_wr = 1'b1;
        @(negedge clk); idle_wr = 1'b0;
        repeat (5) @(negedge clk);
        wake_and_count(k);
        check("R9 idle wake latency", k, 3);
        wake_req = 1'b0;

        // R12 wakeup in run ignored, held level does not wake
        do_reset();
        @(negedge clk); wake_req = 1'b1;
        repeat (8) @(negedge clk);
        check("R12 run unaffected", {30'd0, core_clk_en, halt_flag}, 2);
        strobe_halt();
        repeat (10) @(negedge clk);
        check("R12 held wake ignored", halt_flag, 1);
        wake_req = 1'b0;
        repeat (4) @(negedge clk);
        wake_and_count(k);
        check("R12 fresh edge wakes", k, 3 + SETTLE_CYC);
        wake_req = 1'b0;

        // R11 reset during halt
        do_reset();
        strobe_halt();
        do_reset();
        check("R11 reset in halt core on", core_clk_en, 1);
        check("R11 restart_zero", restart_zero, 1);
        check("R11 no resume_pulse", resume_pulse, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule